// File: doc/BRIEF.md
# Microcode ROM Self-Test Signature Engine

This block runs a built-in self-test of a microcode ROM at start-up. The micro-program counter that normally sequences microcode serves as the address generator. It steps once through every ROM word. Each word that comes back from the ROM is folded into a multiple-input signature register (MISR) that has linear feedback. The test takes a fixed number of cycles. At the end, the block writes the signature XORed with a golden value into a result register that software can read, and raises a done flag. A fault-free ROM therefore leaves a result of zero.

After the test, the same counter goes back to the microcode entry address and runs normal sequencing: it increments, or it loads a jump target. Later self-tests of registers and execution units run from microcode and are not part of this block. A new test can be requested while the block is sequencing normally.

The ROM is synchronous. A word appears on `romData` one clock after its address is on `romAddr`.

Top module: `ucode_rom_selftest`

## Requirements
- R1: While `rstN` is low, `romAddr` is 0, `bistDone` is 0 and `bistResult` is 0.
- R2: The first clock edge after reset is edge 0 of the test. At edge k, for k from 0 to DEPTH-2, `romAddr` moves to k+1. It then holds DEPTH-1 for two more edges.
- R3: The MISR starts from SEED when a test starts. For each of the DEPTH words, taken in address order, the next state is the current state shifted left by one bit, XORed with POLY when the old top bit was 1, then XORed with the ROM word.
- R4: `bistDone` rises at edge DEPTH+1 of the test. That is DEPTH+2 edges after the start and one edge after the last word is folded in.
- R5: When `bistDone` rises, `bistResult` becomes the final MISR value XORed with GOLDEN. It is zero when the ROM holds the expected contents.
- R6: Any single flipped bit in any ROM word gives a non-zero `bistResult`.
- R7: On the edge that sets `bistDone`, `romAddr` becomes RESET_ENTRY. On each later edge it loads `jumpAddr` when `jumpValid` is 1, and otherwise adds one, wrapping at DEPTH.
- R8: While a test is running, `startReq` and `jumpValid` have no effect on `romAddr`, `bistDone` or `bistResult`.
- R9: When `startReq` is 1 while `bistDone` is 1, the next edge sets `romAddr` to 0, reseeds the MISR and clears `bistDone`. That edge counts as the start of a new test. `bistResult` keeps its old value until the new test finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; the self-test starts when it is released |
| startReq | input | 1 | Requests a new self-test while normal sequencing is running |
| jumpValid | input | 1 | Normal mode: load `jumpAddr` into the counter |
| jumpAddr | input | ADDR_W | Jump target for normal sequencing |
| romAddr | output | ADDR_W | Micro-program counter, which drives the ROM address |
| romData | input | DATA_W | ROM word read at the previous cycle's address |
| bistResult | output | DATA_W | Signature XOR golden value; zero means pass |
| bistDone | output | 1 | High once the self-test has finished |

## Verification
The bench runs a behavioural reference model that is compared on every clock. It goes after the following corner cases:

- **Off-by-one in the address walk or the fold window.** A design that skips or repeats the last ROM word would give a non-zero result on a good ROM. A design that folds in the stale word left over from before the test would do the same.
- **Wrong finish cycle or wrong return address.** The bench counts edges to the rise of `bistDone` and checks that the counter lands on the entry address. It also checks that jumps take effect only after the test.
- **Faults at the edges of the ROM.** Bits are flipped in the first word, the last word and two words in between, at different bit positions. A design with a degenerate feedback, or one that loses data at an edge of the ROM, would report a zero result there.
- **Restart.** Start requests made in the middle of a test must be ignored. On a restart, the old result must stay visible until the new one replaces it.

// File: rtl/ucode_bist_pkg.sv
package ucode_bist_pkg;

  typedef enum logic {
    ST_WALK = 1'b0,
    ST_SEQ  = 1'b1
  } bistState_t;

  // strobes from the control into the datapath
  typedef struct packed {
    logic step;     // advance counter during the address walk
    logic compact;  // fold the current ROM word into the signature
    logic finish;   // latch result, raise done, jump to entry
    logic restart;  // begin a new walk from address zero
    logic seqRun;   // normal sequencing (increment or jump)
  } bistStrobe_t;

endpackage

// File: rtl/ucode_bist_misr.sv
module ucode_bist_misr #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    POLY = 16'h100B
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);

  logic fb;
  assign fb = cur[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_low
      assign nxt[i] = (POLY[i] & fb) ^ din[i];
    end else begin : g_up
      assign nxt[i] = cur[i-1] ^ (POLY[i] & fb) ^ din[i];
    end
  end

endmodule

// File: rtl/ucode_bist_ctrl.sv
module ucode_bist_ctrl
  import ucode_bist_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  output bistStrobe_t stb
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = $clog2(DEPTH + 2) + 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(DEPTH - 2);
  localparam logic [CNT_W-1:0] LAST_FOLD = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] FIN_CYC   = CNT_W'(DEPTH + 1);

  bistState_t       state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    stb = '0;
    if (state == ST_WALK) begin
      stb.step    = (cnt <= LAST_STEP);
      stb.compact = (cnt != '0) && (cnt <= LAST_FOLD);
      stb.finish  = (cnt == FIN_CYC);
    end else begin
      stb.restart = startReq;
      stb.seqRun  = !startReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_WALK;
      cnt   <= '0;
    end else if (state == ST_WALK) begin
      if (stb.finish) begin
        state <= ST_SEQ;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (stb.restart) begin
      state <= ST_WALK;
      cnt   <= '0;
    end
  end

  // R8
  walk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WALK && !stb.finish) |=> (state == ST_WALK));

  // R4
  finish_to_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> (state == ST_SEQ && !stb.step && !stb.compact));

endmodule

// File: rtl/ucode_bist_datapath.sv
module ucode_bist_datapath
  import ucode_bist_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 16,
  parameter logic [DATA_W-1:0] POLY        = 16'h100B,
  parameter logic [DATA_W-1:0] SEED        = 16'hFFFF,
  parameter logic [DATA_W-1:0] GOLDEN      = 16'h0000,
  parameter logic [ADDR_W-1:0] RESET_ENTRY = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  bistStrobe_t       stb,
  input  logic              jumpValid,
  input  logic [ADDR_W-1:0] jumpAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [ADDR_W-1:0] upcOut,
  output logic [DATA_W-1:0] resultOut,
  output logic              doneOut
);

  logic [ADDR_W-1:0] upcQ;
  logic [DATA_W-1:0] misrQ;
  logic [DATA_W-1:0] misrNext;
  logic [DATA_W-1:0] resultQ;
  logic              doneQ;

  ucode_bist_misr #(.W(DATA_W), .POLY(POLY)) i_misr (
    .cur (misrQ),
    .din (romData),
    .nxt (misrNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             upcQ <= '0;
    else if (stb.restart)  upcQ <= '0;
    else if (stb.finish)   upcQ <= RESET_ENTRY;
    else if (stb.step)     upcQ <= upcQ + 1'b1;
    else if (stb.seqRun)   upcQ <= jumpValid ? jumpAddr : upcQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             misrQ <= SEED;
    else if (stb.restart)  misrQ <= SEED;
    else if (stb.compact)  misrQ <= misrNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      doneQ   <= 1'b0;
    end else if (stb.restart) begin
      doneQ   <= 1'b0;
    end else if (stb.finish) begin
      resultQ <= misrQ ^ GOLDEN;
      doneQ   <= 1'b1;
    end
  end

  assign upcOut    = upcQ;
  assign resultOut = resultQ;
  assign doneOut   = doneQ;

  // R2
  walk_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |=> (upcQ == $past(upcQ) + 1'b1));

  // R5
  result_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneQ) |-> (resultQ == ($past(misrQ) ^ GOLDEN)));

  // R9
  restart_seed_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.restart |=> (upcQ == '0 && misrQ == SEED && !doneQ && $stable(resultQ)));

  // R7
  jump_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.seqRun && jumpValid) |=> (upcQ == $past(jumpAddr)));

endmodule

// File: rtl/ucode_rom_selftest.sv
module ucode_rom_selftest
  import ucode_bist_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_W      = 16,
  parameter logic [DATA_W-1:0] POLY        = 16'h100B,
  parameter logic [DATA_W-1:0] SEED        = 16'hFFFF,
  parameter logic [DATA_W-1:0] GOLDEN      = 16'h0000,
  parameter logic [ADDR_W-1:0] RESET_ENTRY = 8'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              jumpValid,
  input  logic [ADDR_W-1:0] jumpAddr,
  output logic [ADDR_W-1:0] romAddr,
  input  logic [DATA_W-1:0] romData,
  output logic [DATA_W-1:0] bistResult,
  output logic              bistDone
);

  bistStrobe_t stb;

  ucode_bist_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .stb      (stb)
  );

  ucode_bist_datapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .POLY        (POLY),
    .SEED        (SEED),
    .GOLDEN      (GOLDEN),
    .RESET_ENTRY (RESET_ENTRY)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .jumpValid (jumpValid),
    .jumpAddr  (jumpAddr),
    .romData   (romData),
    .upcOut    (romAddr),
    .resultOut (bistResult),
    .doneOut   (bistDone)
  );

endmodule

// File: tb/test_ucode_rom_selftest.sv
`timescale 1ns/1ps
module test_ucode_rom_selftest;

  localparam int          ADDR_W = 8;
  localparam int          DATA_W = 16;
  localparam int          DEPTH  = 1 << ADDR_W;
  localparam logic [15:0] POLY   = 16'h100B;
  localparam logic [15:0] SEED   = 16'hFFFF;
  localparam logic [7:0]  ENTRY  = 8'h20;

  function automatic logic [15:0] romWord(input int a);
    int v;
    v = (a * 40503) ^ (a << 9) ^ 23130;
    return v[15:0];
  endfunction

  function automatic logic [15:0] mStep(input logic [15:0] m, input logic [15:0] d);
    logic [16:0] t;
    t = {m, 1'b0};
    if (t[16]) t[15:0] = t[15:0] ^ POLY;
    return t[15:0] ^ d;
  endfunction

  function automatic logic [15:0] goldCalc();
    logic [15:0] m;
    m = SEED;
    for (int a = 0; a < DEPTH; a++) m = mStep(m, romWord(a));
    return m;
  endfunction

  localparam logic [15:0] GOLD = goldCalc();

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic jumpValid = 1'b0;
  logic [7:0]  jumpAddr = '0;
  logic [7:0]  romAddr;
  logic [15:0] romData;
  logic [15:0] bistResult;
  logic        bistDone;

  int  checks = 0;
  int  fails  = 0;
  bit  cmpOn  = 0;
  bit  flipOn = 0;
  int  flipAddr = 0;
  int  flipBit  = 0;

  always #2.5 clk = ~clk;

  ucode_rom_selftest #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLY(POLY), .SEED(SEED),
    .GOLDEN(GOLD), .RESET_ENTRY(ENTRY)
  ) i_ucode_rom_selftest (
    .clk(clk), .rstN(rstN), .startReq(startReq), .jumpValid(jumpValid),
    .jumpAddr(jumpAddr), .romAddr(romAddr), .romData(romData),
    .bistResult(bistResult), .bistDone(bistDone)
  );

  function automatic logic [15:0] wordAt(input int a);
    logic [15:0] w;
    w = romWord(a);
    if (flipOn && a == flipAddr) w = w ^ (16'h1 << flipBit);
    return w;
  endfunction

  // synchronous ROM model
  always @(posedge clk) romData <= wordAt(int'(romAddr));

  // behavioural reference model
  int          mCyc;
  bit          mWalking;
  int          mAddr;
  logic [15:0] mMisr;
  logic [15:0] mRes;
  bit          mDone;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCyc = 0; mWalking = 1; mAddr = 0; mMisr = SEED; mRes = '0; mDone = 0;
    end else if (mWalking) begin
      if (mCyc >= 1 && mCyc <= DEPTH) mMisr = mStep(mMisr, wordAt(mCyc - 1));
      if (mCyc <= DEPTH - 2) mAddr = mCyc + 1;
      if (mCyc == DEPTH + 1) begin
        mRes = mMisr ^ GOLD; mDone = 1; mAddr = int'(ENTRY); mWalking = 0;
      end
      mCyc++;
    end else if (startReq) begin
      mWalking = 1; mCyc = 0; mAddr = 0; mMisr = SEED; mDone = 0;
    end else if (jumpValid) begin
      mAddr = int'(jumpAddr);
    end else begin
      mAddr = (mAddr + 1) % DEPTH;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmpOn) begin
      chk(int'(romAddr) == mAddr, "R2/R7/R8 romAddr", 32'(romAddr), 32'(mAddr));
      chk(bistDone == mDone, "R4/R8 bistDone", 32'(bistDone), 32'(mDone));
      chk(bistResult == mRes, "R3/R5/R9 bistResult", 32'(bistResult), 32'(mRes));
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic restartAndWait(input bit midPoke);
    @(negedge clk); startReq = 1'b1;
    @(negedge clk); startReq = 1'b0;
    chk(!bistDone, "R9 done cleared on restart", 32'(bistDone), 0);
    chk(romAddr == 8'h00, "R9 address zero on restart", 32'(romAddr), 0);
    for (int k = 0; k < DEPTH + 1; k++) begin
      if (midPoke && k == 40) begin startReq = 1'b1; jumpValid = 1'b1; jumpAddr = 8'hC3; end
      if (midPoke && k == 42) begin startReq = 1'b0; jumpValid = 1'b0; end
      @(negedge clk);
    end
    chk(!bistDone, "R4 done still low one edge before finish", 32'(bistDone), 0);
    @(negedge clk);
    chk(bistDone, "R4 done at budget end", 32'(bistDone), 1);
  endtask

  initial begin
    #1;
    chk(romAddr == 8'h00, "R1 reset address", 32'(romAddr), 0);
    chk(!bistDone, "R1 reset done", 32'(bistDone), 0);
    chk(bistResult == 16'h0, "R1 reset result", 32'(bistResult), 0);
    repeat (3) @(negedge clk);
    chk(romAddr == 8'h00 && !bistDone, "R1 held in reset", 32'(romAddr), 0);
    cmpOn = 1;
    rstN = 1'b1;

    // start-up walk
    @(negedge clk);
    chk(romAddr == 8'h01, "R2 first step", 32'(romAddr), 1);
    repeat (DEPTH - 2) @(negedge clk);
    chk(romAddr == 8'(DEPTH - 1), "R2 last address", 32'(romAddr), 32'(DEPTH - 1));
    @(negedge clk);
    chk(romAddr == 8'(DEPTH - 1) && !bistDone, "R2 address held", 32'(romAddr), 32'(DEPTH - 1));
    @(negedge clk);
    chk(!bistDone, "R4 not yet done", 32'(bistDone), 0);
    @(negedge clk);
    chk(bistDone, "R4 done after DEPTH+2 edges", 32'(bistDone), 1);
    chk(bistResult == 16'h0, "R5 good ROM gives zero", 32'(bistResult), 0);
    chk(romAddr == ENTRY, "R7 return to entry", 32'(romAddr), 32'(ENTRY));

    // normal sequencing
    @(negedge clk);
    chk(romAddr == ENTRY + 8'h1, "R7 increment", 32'(romAddr), 32'(ENTRY + 8'h1));
    jumpValid = 1'b1; jumpAddr = 8'hFF;
    @(negedge clk);
    jumpValid = 1'b0;
    chk(romAddr == 8'hFF, "R7 jump load", 32'(romAddr), 32'hFF);
    @(negedge clk);
    chk(romAddr == 8'h00, "R7 wrap", 32'(romAddr), 0);

    // restart with pokes during the walk
    restartAndWait(1'b1);
    chk(bistResult == 16'h0, "R8 pokes ignored, result zero", 32'(bistResult), 0);

    // single-bit faults
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      flipOn = 1;
      case (i)
        0: begin flipAddr = 0;         flipBit = 0;  end
        1: begin flipAddr = DEPTH - 1; flipBit = 15; end
        2: begin flipAddr = 77;        flipBit = 6;  end
        default: begin flipAddr = 128; flipBit = 9;  end
      endcase
      restartAndWait(1'b0);
      chk(bistResult != 16'h0, "R6 flipped bit detected", 32'(bistResult), 32'(mRes));
      chk(bistResult == mRes, "R3 faulty signature value", 32'(bistResult), 32'(mRes));
    end

    // restart keeps old result until new finish
    @(negedge clk);
    flipOn = 0;
    begin
      logic [15:0] prev;
      prev = bistResult;
      @(negedge clk); startReq = 1'b1;
      @(negedge clk); startReq = 1'b0;
      repeat (10) @(negedge clk);
      chk(bistResult == prev, "R9 result held during new walk", 32'(bistResult), 32'(prev));
      repeat (DEPTH - 8) @(negedge clk);
      chk(bistDone && bistResult == 16'h0, "R9 new result after restart", 32'(bistResult), 0);
    end

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule